// File: doc/BRIEF.md
# Programmable Decimation Delay Line

This block is the sample-storage backbone between the taps of a symmetric FIR filter. Accepted input samples travel down two chains of delay stages: a forward chain and a reverse chain. Each chain exposes one tap per stage boundary, so a multiplier array placed next to it sees, for each tap, the sample that lies a whole number of stage lengths in the past. A single 4-bit setting gives both the stage length and the decimation factor. The two values are always equal, ranging from 1 to 16 samples. A tap vector is presented once for every factor-many accepted samples.

The reverse chain can take the input stream directly, or it can take the stream after block reversal. In block reversal, each group of factor-many samples, aligned to the decimation phase, is emitted in backward order during the following group. This uses a two-bank ping-pong store and adds one group of latency. The input is a valid/ready stream. The tap output is a valid/ready stream that carries both tap vectors together.

Back-pressure rules are as follows. A tap vector that is offered stays offered, with unchanged contents, until `out_ready` is high. `in_ready` is low exactly when a vector is pending and `out_ready` is low. A sample counts only on a cycle where `in_valid` and `in_ready` are both high. `code` and `rev_en` are static settings: change them only while `rst_n` is held low.

Top module: `decim_delay_line`

## Requirements
- R1: With `code` = 0, the factor is 1: every accepted sample produces a tap vector, and forward tap s holds the sample accepted s samples before the current one.
- R2: With `code` = n, the factor is F = n+1. Tap vectors appear after the accepted samples whose index k (counted from 0 after reset) satisfies k mod F = F-1. Forward tap s (bits s*DW +: DW of `fwd_taps`) holds the sample with index k - s*F.
- R3: Exactly one tap vector is produced per F accepted samples, and none is produced on a cycle without an accepted sample.
- R4: With `rev_en` = 1, the reverse-chain input at index j = g*F + p (p < F) is the sample with index j - 2p - 1 when g >= 1, and zero for g = 0. Reverse tap s holds that stream at index k - s*F.
- R5: With `rev_en` = 0, reverse tap s holds the same sample as forward tap s.
- R6: Reset clears all stored samples and the decimation phase. After reset, `out_valid` is 0, `in_ready` is 1, and any tap that refers to an index below 0 reads zero.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1, both tap outputs stay unchanged, and `in_ready` is 0. Otherwise `in_ready` is 1.
- R8: Cycles without an accepted sample change neither the stored samples nor the phase, whatever value `in_data` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| code | input | 4 | Factor and stage length minus one; static |
| rev_en | input | 1 | Block reversal in front of the reverse chain; static |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take the sample |
| in_data | input | DW (10) | Input sample |
| out_valid | output | 1 | Tap vector offered |
| out_ready | input | 1 | Consumer takes the tap vector |
| fwd_taps | output | NTAP*DW (40) | Forward taps, tap s at bits s*DW +: DW |
| rev_taps | output | NTAP*DW (40) | Reverse taps, same packing |

## Verification
The bound assertions check the handshake on every cycle. They confirm that a stalled vector holds both its valid flag and its contents, that `in_ready` drops during a stall, and that no vector appears without an accepted sample. They also confirm that a factor of 1 produces a vector after every accepted sample and that the output is idle after reset. Tap contents depend on the history of accepted samples, so only the bench's scenarios can show them. The bench runs random and bursty streams at several codes, with and without reversal, and compares each vector against a model of indices. The first vectors after each reset show the clearing, and idle cycles carrying garbage data show that unaccepted samples have no effect.

// File: rtl/ddl_pkg.sv
package ddl_pkg;
  localparam int unsigned MAX_FACTOR = 16;
  localparam int unsigned PTR_W      = $clog2(MAX_FACTOR);
  localparam int unsigned FAC_W      = PTR_W + 1;

  typedef logic [3:0]       code_t;
  typedef logic [PTR_W-1:0] ptr_t;
  typedef logic [FAC_W-1:0] fac_t;

  function automatic fac_t factor_of(code_t c);
    return fac_t'(c) + fac_t'(1);
  endfunction
endpackage

// File: rtl/ddl_phase.sv
module ddl_phase
  import ddl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  fac_t factor,
  output ptr_t phase,
  output ptr_t wptr,
  output logic last
);
  assign last = (fac_t'(phase) == factor - fac_t'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
      wptr  <= '0;
    end else if (adv) begin
      wptr  <= wptr + ptr_t'(1);
      phase <= last ? '0 : phase + ptr_t'(1);
    end
  end
endmodule

// File: rtl/ddl_delay_stage.sv
module ddl_delay_stage
  import ddl_pkg::*;
#(
  parameter int unsigned DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  ptr_t          wptr,
  input  ptr_t          rptr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] ring [MAX_FACTOR];

  assign dout = ring[rptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(MAX_FACTOR); i++) ring[i] <= '0;
    end else if (adv) begin
      ring[wptr] <= din;
    end
  end
endmodule

// File: rtl/ddl_block_reverse.sv
module ddl_block_reverse
  import ddl_pkg::*;
#(
  parameter int unsigned DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  ptr_t          phase,
  input  logic          last,
  input  fac_t          factor,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] bank0 [MAX_FACTOR];
  logic [DW-1:0] bank1 [MAX_FACTOR];
  logic          wsel;
  fac_t          mirror;
  ptr_t          ridx;

  assign mirror = factor - fac_t'(1) - fac_t'(phase);
  assign ridx   = mirror[PTR_W-1:0];
  assign dout   = wsel ? bank0[ridx] : bank1[ridx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wsel <= 1'b0;
      for (int i = 0; i < int'(MAX_FACTOR); i++) begin
        bank0[i] <= '0;
        bank1[i] <= '0;
      end
    end else if (adv) begin
      if (wsel) bank1[phase] <= din;
      else      bank0[phase] <= din;
      if (last) wsel <= ~wsel;
    end
  end
endmodule

// File: rtl/decim_delay_line.sv
module decim_delay_line
  import ddl_pkg::*;
#(
  parameter int unsigned DW   = 10,
  parameter int unsigned NTAP = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         code,
  input  logic               rev_en,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DW-1:0]      in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [NTAP*DW-1:0] fwd_taps,
  output logic [NTAP*DW-1:0] rev_taps
);
  localparam int unsigned NSTAGE = NTAP - 1;

  fac_t          factor;
  fac_t          back;
  ptr_t          phase, wptr, rptr;
  logic          last, adv;
  logic [DW-1:0] rev_src, rev_in;
  logic [DW-1:0] fchain [NTAP];
  logic [DW-1:0] rchain [NTAP];
  logic [NTAP*DW-1:0] fwd_next, rev_next;

  assign factor   = factor_of(code);
  assign in_ready = !out_valid || out_ready;
  assign adv      = in_valid && in_ready;
  assign back     = fac_t'(wptr) + fac_t'(MAX_FACTOR) - factor;
  assign rptr     = back[PTR_W-1:0];

  ddl_phase u_phase (
    .clk(clk), .rst_n(rst_n), .adv(adv), .factor(factor),
    .phase(phase), .wptr(wptr), .last(last)
  );

  ddl_block_reverse #(.DW(DW)) u_rev (
    .clk(clk), .rst_n(rst_n), .adv(adv), .phase(phase), .last(last),
    .factor(factor), .din(in_data), .dout(rev_src)
  );

  assign rev_in    = rev_en ? rev_src : in_data;
  assign fchain[0] = in_data;
  assign rchain[0] = rev_in;

  for (genvar s = 1; s <= NSTAGE; s++) begin : g_stage
    ddl_delay_stage #(.DW(DW)) u_fwd (
      .clk(clk), .rst_n(rst_n), .adv(adv), .wptr(wptr), .rptr(rptr),
      .din(fchain[s-1]), .dout(fchain[s])
    );
    ddl_delay_stage #(.DW(DW)) u_bwd (
      .clk(clk), .rst_n(rst_n), .adv(adv), .wptr(wptr), .rptr(rptr),
      .din(rchain[s-1]), .dout(rchain[s])
    );
  end

  for (genvar t = 0; t < NTAP; t++) begin : g_pack
    assign fwd_next[t*DW +: DW] = fchain[t];
    assign rev_next[t*DW +: DW] = rchain[t];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      fwd_taps  <= '0;
      rev_taps  <= '0;
    end else if (adv && last) begin
      out_valid <= 1'b1;
      fwd_taps  <= fwd_next;
      rev_taps  <= rev_next;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ddl_checker.sv
module ddl_checker #(
  parameter int unsigned DW   = 10,
  parameter int unsigned NTAP = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [3:0]         code,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [NTAP*DW-1:0] fwd_taps,
  input logic [NTAP*DW-1:0] rev_taps
);
  a_r7_hold_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(fwd_taps) && $stable(rev_taps)));

  a_r7_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r3_no_vector_without_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) && !(out_valid && !out_ready)) |=> !out_valid);

  a_r1_unit_factor_every_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 4'd0 && in_valid && in_ready) |=> out_valid);

  a_r6_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);
endmodule

bind decim_delay_line ddl_checker #(.DW(DW), .NTAP(NTAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .code(code), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .fwd_taps(fwd_taps), .rev_taps(rev_taps)
);

// File: tb/decim_delay_line_tb.sv
`timescale 1ns/1ps
module decim_delay_line_tb;
  localparam int DW = 10;
  localparam int NTAP = 4;
  localparam int W = NTAP*DW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] code = '0;
  logic rev_en = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [W-1:0] fwd_taps, rev_taps;

  int checks = 0, fails = 0;
  logic [DW-1:0] xs [4096];
  int nacc, fac, vecs;
  bit rv;
  logic [W-1:0] qf [$];
  logic [W-1:0] qr [$];
  bit done = 0;

  always #10 clk = ~clk;

  decim_delay_line #(.DW(DW), .NTAP(NTAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .code(code), .rev_en(rev_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .fwd_taps(fwd_taps), .rev_taps(rev_taps)
  );

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] gx(int j);
    return (j < 0) ? '0 : xs[j];
  endfunction

  function automatic logic [DW-1:0] gy(int j);
    int p;
    if (j < 0) return '0;
    if (!rv) return gx(j);
    if (j / fac == 0) return '0;
    p = j % fac;
    return gx(j - 2*p - 1);
  endfunction

  function automatic logic [W-1:0] exp_f(int k);
    logic [W-1:0] v;
    for (int s = 0; s < NTAP; s++) v[s*DW +: DW] = gx(k - s*fac);
    return v;
  endfunction

  function automatic logic [W-1:0] exp_r(int k);
    logic [W-1:0] v;
    for (int s = 0; s < NTAP; s++) v[s*DW +: DW] = gy(k - s*fac);
    return v;
  endfunction

  task automatic do_reset(input int c, input bit r);
    @(negedge clk);
    rst_n = 1'b0; code = 4'(c); rev_en = r;
    in_valid = 1'b0; out_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!out_valid, "R6 out_valid after reset", W'(out_valid), '0);
    check(in_ready, "R6 in_ready after reset", W'(in_ready), W'(1));
    fac = c + 1; rv = r; nacc = 0; vecs = 0;
    qf.delete(); qr.delete();
  endtask

  // One cycle: drive at the negedge, evaluate handshakes, the edge follows.
  task automatic step(input int pv, input int pr);
    logic [W-1:0] ef, er;
    bit stalled;
    logic [W-1:0] hold_f;
    in_valid  = ($urandom_range(99) < pv);
    in_data   = DW'($urandom);
    out_ready = ($urandom_range(99) < pr);
    #1;
    check(in_ready == (!out_valid || out_ready), "R7 in_ready rule", W'(in_ready), W'(!out_valid || out_ready));
    if (out_valid && out_ready) begin
      if (qf.size() == 0) begin
        check(0, "R3 unexpected vector", fwd_taps, '0);
      end else begin
        ef = qf.pop_front(); er = qr.pop_front();
        check(fwd_taps == ef, (fac == 1) ? "R1 fwd taps" : "R2 fwd taps", fwd_taps, ef);
        check(rev_taps == er, rv ? "R4 rev taps" : "R5 rev taps", rev_taps, er);
      end
    end
    stalled = out_valid && !out_ready;
    hold_f  = fwd_taps;
    if (in_valid && in_ready) begin
      xs[nacc] = in_data;
      if (nacc % fac == fac - 1) begin
        qf.push_back(exp_f(nacc));
        qr.push_back(exp_r(nacc));
        vecs++;
      end
      nacc++;
    end
    @(negedge clk);
    if (stalled) begin
      #0;
      check(out_valid && fwd_taps == hold_f, "R7 stalled vector held", fwd_taps, hold_f);
    end
  endtask

  task automatic run_phase(input int c, input bit r, input int n, input int pv, input int pr);
    do_reset(c, r);
    for (int i = 0; i < n; i++) step(pv, pr);
    // drain: no samples, consumer always ready; garbage data must not count (R8)
    for (int i = 0; i < 3; i++) step(0, 100);
    check(qf.size() == 0, "R3 vectors per factor", W'(qf.size()), '0);
    check(vecs == nacc / fac, "R3 vector count", W'(vecs), W'(nacc / fac));
    for (int i = 0; i < 8; i++) begin
      step(0, 100);
      check(!out_valid, "R8 idle cycles make no vector", W'(out_valid), '0);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (2) @(negedge clk);
    run_phase(0, 0, 200, 80, 70);
    run_phase(0, 1, 200, 90, 60);
    run_phase(1, 0, 300, 70, 80);
    run_phase(2, 1, 300, 85, 50);
    run_phase(3, 1, 400, 100, 100);
    run_phase(7, 0, 400, 75, 40);
    run_phase(15, 1, 600, 90, 70);
    run_phase(15, 0, 400, 100, 100);
    run_phase(5, 1, 500, 60, 30);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule